// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block produces the signed offset that a spread-spectrum clock controller adds to the fractional divide word of a fractional-N PLL. Every accepted output beat is one reference-cycle sample of a triangle profile. The profile spreads the synthesized clock either downward from nominal or symmetrically around it. Two 32-bit control words supply a bypass flag, a spread-type flag, a 4-bit modulation rate code and a 5-bit depth code. A separate flag says whether fractional mode (the delta-sigma modulator) is enabled. The block also takes the nominal fractional word, because the depth is expressed as a fraction of it.

The output is a valid/ready stream. Valid rises one clock after reset is released and then stays high, because a sample is always available. The consumer applies back-pressure by holding ready low. While ready is low the presented sample holds still and the profile does not advance. One modulation period is therefore a fixed number of accepted beats, not of clock cycles. A new set of control fields takes effect only at the first sample of a period, so a ramp never jumps partway through. Spreading stops as soon as it is bypassed, fractional mode is off, or the rate code is zero. From then on every accepted sample is zero, and spreading restarts from the beginning of a period when it is enabled again.

Top module: `sstg_top`

## Requirements
- R1: While rst_n is low, ofs_valid and ofs_data are 0. One clock after reset is released, ofs_valid becomes 1 and stays 1.
- R2: The control fields are decoded at fixed bit positions. Bypass is ctrl_word bit 31 (1 = bypass). Spread type is ctrl_word bit 4 (0 = center, 1 = down). The rate code is spread_word[19:16] and the depth code is spread_word[4:0]. All other bits have no effect.
- R3: Each beat accepted while frac_en is 0, bypass is 1, or the rate code is 0 loads a zero sample and returns the profile to phase 0.
- R4: The amplitude A is floor(depth × nom_frac / 1000), so one depth step is 0.1 % of the nominal word. A depth code of 0 gives all-zero samples.
- R5: In down spread the sample at phase p is −floor(A·t/H). Here H = rate × 2^UB, and t = p for p < H, otherwise t = 2H − p. Samples therefore span 0 to −A.
- R6: In center spread the sample is floor(A/2) − floor(A·t/H). Samples span +floor(A/2) to floor(A/2) − A.
- R7: A period is 2H accepted beats. Phase 0 is the first beat accepted after spreading is enabled.
- R8: The rate, type, depth and nominal word are captured only at a beat that starts a period. A change that arrives mid-period applies at the next phase 0. A change present at the beat that follows the last phase applies to that beat.
- R9: While ofs_valid is 1 and ofs_ready is 0, ofs_data holds and the phase does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frac_en | input | 1 | Fractional (delta-sigma) mode enabled |
| ctrl_word | input | 32 | Control word: bypass bit 31, spread type bit 4 |
| spread_word | input | 32 | Spread word: rate code 19:16, depth code 4:0 |
| nom_frac | input | FRAC_W | Nominal fractional divide word |
| ofs_valid | output | 1 | Offset sample valid |
| ofs_ready | input | 1 | Consumer accepts the sample |
| ofs_data | output | FRAC_W+DEPTH_W−8 | Signed offset sample |

## Verification
Two functions can land on the same clock edge: the period wrap, which captures the fields, and an operator change to those fields or to the gating. The bench provokes this by watching its own reference model. It changes the fields just before the beat that follows the last phase, and in another run it changes them mid-ramp. The result must show the new profile from phase 0 in the first case and the old ramp continuing in the second. Random ready stalls are mixed in so that the coincidence also occurs while the stream is held, and every sample is compared against the model on every clock.

// File: rtl/sstg_pkg.sv
package sstg_pkg;
  localparam int BYP_BIT   = 31;
  localparam int TYPE_BIT  = 4;
  localparam int RATE_LSB  = 16;
  localparam int RATE_W    = 4;
  localparam int DEPTH_LSB = 0;
  localparam int DEPTH_W   = 5;
  localparam int DEPTH_DEN = 1000;

  typedef struct packed {
    logic               down;
    logic [RATE_W-1:0]  rate;
    logic [DEPTH_W-1:0] depth;
  } ss_fields_t;
endpackage

// File: rtl/sstg_field_decode.sv
module sstg_field_decode
  import sstg_pkg::*;
(
  input  logic [31:0] ctrl_word,
  input  logic [31:0] spread_word,
  input  logic        frac_en,
  output ss_fields_t  fld,
  output logic        gate_on
);
  logic unused_bits;

  assign fld.down  = ctrl_word[TYPE_BIT];
  assign fld.rate  = spread_word[RATE_LSB +: RATE_W];
  assign fld.depth = spread_word[DEPTH_LSB +: DEPTH_W];

  // spreading only in fractional mode, not bypassed, nonzero rate
  assign gate_on = frac_en & ~ctrl_word[BYP_BIT] & (fld.rate != '0);

  assign unused_bits = ^{ctrl_word[30:5], ctrl_word[3:0],
                         spread_word[31:20], spread_word[15:5]};
endmodule

// File: rtl/sstg_depth_scale.sv
module sstg_depth_scale
  import sstg_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int AW     = FRAC_W + DEPTH_W - 9
) (
  input  logic [DEPTH_W-1:0] depth,
  input  logic [FRAC_W-1:0]  nom,
  output logic [AW-1:0]      amp
);
  // floor(p/1000) as a multiply by a rounded-up reciprocal; exact for p < 2^PW
  localparam int PW = DEPTH_W + FRAC_W;
  localparam int SH = PW + 10;
  localparam int MW = SH - 9;
  localparam int XW = PW + MW;
  localparam logic [MW-1:0] RECIP =
    MW'(((64'd1 << SH) + 64'(DEPTH_DEN) - 64'd1) / 64'(DEPTH_DEN));

  logic [PW-1:0] prod;
  logic [XW-1:0] scaled;

  always_comb begin
    prod   = PW'(depth) * PW'(nom);
    scaled = XW'(prod) * XW'(RECIP);
    amp    = AW'(scaled >> SH);
  end
endmodule

// File: rtl/sstg_tri_shaper.sv
module sstg_tri_shaper
  import sstg_pkg::*;
#(
  parameter int AW  = 20,
  parameter int UB  = 8,
  parameter int PHW = RATE_W + UB + 1
) (
  input  logic [PHW-1:0]     ph,
  input  logic [RATE_W-1:0]  rate,
  input  logic               down,
  input  logic [AW-1:0]      amp,
  output logic signed [AW:0] smp
);
  localparam int TW = RATE_W + UB;
  localparam int NW = AW + RATE_W;
  localparam int S  = NW + 4;
  localparam int MW = S + 1;
  localparam int NR = 2 ** RATE_W;

  // reciprocal of each rate code, so division by the code is a multiply
  logic [MW-1:0] recip_tbl [NR];
  for (genvar d = 0; d < NR; d++) begin : g_rc
    if (d == 0) begin : g_zero
      assign recip_tbl[d] = '0;
    end else begin : g_div
      assign recip_tbl[d] = MW'(((64'd1 << S) + 64'(d) - 64'd1) / 64'(d));
    end
  end

  logic [PHW-1:0]   half_len;
  logic [PHW-1:0]   full_len;
  logic [TW-1:0]    tri_pos;
  logic [AW+TW-1:0] prod;
  logic [NW-1:0]    n_scaled;
  logic [NW+MW-1:0] q_prod;
  logic [AW-1:0]    ramp;
  logic [AW-1:0]    half_amp;

  always_comb begin
    half_len = {1'b0, rate, {UB{1'b0}}};
    full_len = {rate, {(UB+1){1'b0}}};
    tri_pos  = (ph < half_len) ? TW'(ph) : TW'(full_len - ph);
    prod     = (AW+TW)'(amp) * (AW+TW)'(tri_pos);
    n_scaled = NW'(prod >> UB);
    q_prod   = (NW+MW)'(n_scaled) * (NW+MW)'(recip_tbl[rate]);
    ramp     = AW'(q_prod >> S);
    half_amp = amp >> 1;
    if (down) smp = -$signed({1'b0, ramp});
    else      smp = $signed({1'b0, half_amp}) - $signed({1'b0, ramp});
  end
endmodule

// File: rtl/sstg_phase_seq.sv
module sstg_phase_seq
  import sstg_pkg::*;
#(
  parameter int AW  = 20,
  parameter int UB  = 8,
  parameter int PHW = RATE_W + UB + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               gate_on,
  input  logic [RATE_W-1:0]  rate_live,
  input  logic               down_live,
  input  logic [AW-1:0]      amp_live,
  output logic [PHW-1:0]     ph_nx,
  output logic [RATE_W-1:0]  rate_nx,
  output logic               down_nx,
  output logic [AW-1:0]      amp_nx,
  input  logic signed [AW:0] smp,
  output logic               run,
  output logic signed [AW:0] data
);
  logic [PHW-1:0]    ph_q;
  logic [RATE_W-1:0] rate_q;
  logic              down_q;
  logic [AW-1:0]     amp_q;
  logic              run_q;
  logic signed [AW:0] data_q;
  logic [PHW-1:0]    two_h;
  logic              last;
  logic              restart;

  always_comb begin
    two_h   = {rate_q, {(UB+1){1'b0}}};
    last    = (ph_q == two_h - PHW'(1));
    restart = ~run_q | last;
    ph_nx   = restart ? '0        : ph_q + PHW'(1);
    rate_nx = restart ? rate_live : rate_q;
    down_nx = restart ? down_live : down_q;
    amp_nx  = restart ? amp_live  : amp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= '0;
      rate_q <= '0;
      down_q <= 1'b0;
      amp_q  <= '0;
      run_q  <= 1'b0;
      data_q <= '0;
    end else if (adv) begin
      if (!gate_on) begin
        run_q  <= 1'b0;
        ph_q   <= '0;
        data_q <= '0;
      end else begin
        run_q  <= 1'b1;
        ph_q   <= ph_nx;
        rate_q <= rate_nx;
        down_q <= down_nx;
        amp_q  <= amp_nx;
        data_q <= smp;
      end
    end
  end

  assign run  = run_q;
  assign data = data_q;

  // R5: down spread never goes positive and never below -A
  p_down_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && down_q) |-> (data_q <= 0 && data_q >= -$signed({1'b0, amp_q})));

  // R6: center spread stays inside +A/2 .. A/2-A
  p_center_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !down_q) |->
      (data_q <= $signed({1'b0, amp_q >> 1}) &&
       data_q >= $signed({1'b0, amp_q >> 1}) - $signed({1'b0, amp_q})));

  // R7: phase stays inside one period, and starts at zero
  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ph_q < two_h));
  p_phase_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (ph_q == '0));

  // R8: captured fields only move at a period start
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last) |=> $stable({rate_q, down_q, amp_q}));
endmodule

// File: rtl/sstg_top.sv
module sstg_top
  import sstg_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int UB     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frac_en,
  input  logic [31:0]                       ctrl_word,
  input  logic [31:0]                       spread_word,
  input  logic [FRAC_W-1:0]                 nom_frac,
  output logic                              ofs_valid,
  input  logic                              ofs_ready,
  output logic signed [FRAC_W+DEPTH_W-9:0]  ofs_data
);
  localparam int AW  = FRAC_W + DEPTH_W - 9;
  localparam int PHW = RATE_W + UB + 1;

  ss_fields_t        fld;
  logic              gate_on;
  logic [AW-1:0]     amp_live;
  logic [AW-1:0]     amp_nx;
  logic [PHW-1:0]    ph_nx;
  logic [RATE_W-1:0] rate_nx;
  logic              down_nx;
  logic signed [AW:0] smp;
  logic signed [AW:0] data;
  logic              run;
  logic              vld_q;
  logic              adv;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= 1'b1;
  end

  assign adv       = vld_q & ofs_ready;
  assign ofs_valid = vld_q;
  assign ofs_data  = data;

  sstg_field_decode u_dec (
    .ctrl_word   (ctrl_word),
    .spread_word (spread_word),
    .frac_en     (frac_en),
    .fld         (fld),
    .gate_on     (gate_on)
  );

  sstg_depth_scale #(.FRAC_W(FRAC_W), .AW(AW)) u_scale (
    .depth (fld.depth),
    .nom   (nom_frac),
    .amp   (amp_live)
  );

  sstg_phase_seq #(.AW(AW), .UB(UB), .PHW(PHW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .gate_on   (gate_on),
    .rate_live (fld.rate),
    .down_live (fld.down),
    .amp_live  (amp_live),
    .ph_nx     (ph_nx),
    .rate_nx   (rate_nx),
    .down_nx   (down_nx),
    .amp_nx    (amp_nx),
    .smp       (smp),
    .run       (run),
    .data      (data)
  );

  sstg_tri_shaper #(.AW(AW), .UB(UB), .PHW(PHW)) u_shape (
    .ph   (ph_nx),
    .rate (rate_nx),
    .down (down_nx),
    .amp  (amp_nx),
    .smp  (smp)
  );

  // R1: once valid, it stays valid
  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_valid |=> ofs_valid);

  // R9: a stalled sample holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && !ofs_ready) |=> $stable(ofs_data));

  // R3: not spreading means a zero sample
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (ofs_data == '0));
endmodule

// File: tb/sstg_top_tb_top.sv
`timescale 1ns/100ps
module sstg_top_tb_top;
  localparam int FRAC_W = 24;
  localparam int UB     = 3;
  localparam int U      = 1 << UB;
  localparam int OW     = FRAC_W + 5 - 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frac_en = 1'b0;
  logic [31:0]       ctrl_word = 32'h8000_0000;
  logic [31:0]       spread_word = 32'h0;
  logic [FRAC_W-1:0] nom_frac = '0;
  logic              ofs_valid;
  logic              ofs_ready = 1'b1;
  logic signed [OW-1:0] ofs_data;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // reference model state
  bit     m_vld, m_run, m_down;
  longint m_ph, m_rate, m_amp, m_data;
  longint samples[$];

  always #2.5 clk = ~clk;

  sstg_top #(.FRAC_W(FRAC_W), .UB(UB)) dut_i (
    .clk(clk), .rst_n(rst_n), .frac_en(frac_en), .ctrl_word(ctrl_word),
    .spread_word(spread_word), .nom_frac(nom_frac), .ofs_valid(ofs_valid),
    .ofs_ready(ofs_ready), .ofs_data(ofs_data));

  function automatic longint shape(longint ph, longint rate, bit down, longint amp);
    longint h, t, ramp;
    h = rate * U;
    t = (ph < h) ? ph : 2 * h - ph;
    ramp = (amp * t) / h;
    return down ? -ramp : (amp / 2) - ramp;
  endfunction

  always @(posedge clk) begin
    bit adv, gate;
    longint rate_in;
    if (!rst_n) begin
      m_vld = 0; m_run = 0; m_ph = 0; m_data = 0;
    end else begin
      adv = m_vld && ofs_ready;
      rate_in = spread_word[19:16];
      gate = frac_en && !ctrl_word[31] && rate_in != 0;
      if (adv) begin
        if (!gate) begin
          m_run = 0; m_ph = 0; m_data = 0;
        end else begin
          if (!m_run || m_ph == 2 * m_rate * U - 1) begin
            m_ph = 0;
            m_rate = rate_in;
            m_down = ctrl_word[4];
            m_amp = (longint'(spread_word[4:0]) * longint'(nom_frac)) / 1000;
          end else m_ph++;
          m_run = 1;
          m_data = shape(m_ph, m_rate, m_down, m_amp);
        end
      end
      m_vld = 1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (ofs_valid !== m_vld || longint'(ofs_data) !== m_data) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               rst_n ? cur_req : "R1", ofs_valid, longint'(ofs_data), m_vld, m_data);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic collect(int n);
    samples.delete();
    repeat (n) begin
      @(negedge clk);
      samples.push_back(longint'(ofs_data));
    end
    #1;
  endtask

  task automatic check_val(string req, string what, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wait_phase(longint ph);
    do @(negedge clk); while (!(m_run && m_ph == ph));
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
  end

  initial begin
    longint mn, mx, z0, z1;
    step(5);
    check_val("R1", "valid during reset", longint'(ofs_valid), 0);
    rst_n = 1'b1;
    step(1);
    check_val("R1", "valid after reset", longint'(ofs_valid), 1);

    // R3: fractional mode off, then bypass set
    cur_req = "R3";
    spread_word = 32'h0002_001F; nom_frac = 24'h10_0000; ctrl_word = 32'h0;
    step(10);
    frac_en = 1'b1; ctrl_word = 32'h8000_0010;
    step(10);
    check_val("R3", "bypassed sample", longint'(ofs_data), 0);

    // R5, R4, R7: down spread rate 2, depth 31, nominal 2^20
    cur_req = "R5";
    ctrl_word = 32'h0000_0010;
    collect(80);
    mn = 0; z0 = -1; z1 = -1;
    foreach (samples[i]) begin
      if (samples[i] < mn) mn = samples[i];
      if (samples[i] == 0) begin
        if (z0 < 0) z0 = i; else if (z1 < 0) z1 = i;
      end
    end
    check_val("R4", "down peak", mn, -32505);
    check_val("R7", "period beats", z1 - z0, 2 * 2 * U);

    // R2, R6: center spread, rate 6, depth 1, junk in unused bits
    cur_req = "R2";
    ctrl_word = 32'h7FFF_FFEF; spread_word = 32'hFFF6_FFE1; nom_frac = 24'hFF_FFFF;
    step(40);
    collect(200);
    mn = 0; mx = 0;
    foreach (samples[i]) begin
      if (samples[i] < mn) mn = samples[i];
      if (samples[i] > mx) mx = samples[i];
    end
    check_val("R6", "center high peak", mx, 8388);
    check_val("R6", "center low peak", mn, -8389);

    // R3: rate code zero stops spreading
    cur_req = "R3";
    spread_word = 32'h0000_001F;
    step(12);
    check_val("R3", "rate zero sample", longint'(ofs_data), 0);

    // R9: random back-pressure, down spread rate 3 depth 12
    cur_req = "R9";
    ctrl_word = 32'h0000_0010; spread_word = 32'h0003_000C; nom_frac = 24'h12_3456;
    for (int i = 0; i < 300; i++) begin
      ofs_ready = ($urandom % 3) != 0;
      step(1);
    end
    ofs_ready = 1'b1;

    // R8: mid-period change must wait for the next period
    cur_req = "R8";
    spread_word = 32'h0002_001F; nom_frac = 24'h10_0000;
    step(40);
    wait_phase(5);
    ctrl_word = 32'h0000_0000; spread_word = 32'h0002_0004;
    step(1);
    check_val("R8", "mid-period sample", longint'(ofs_data), -((32505 * 6) / 16));
    // R8: change exactly at the wrap beat applies at once
    wait_phase(2 * 2 * U - 1);
    spread_word = 32'h0001_0014;
    ctrl_word = 32'h0000_0010;
    step(1);
    check_val("R8", "wrap sample", longint'(ofs_data), 0);
    step(3);

    // wrap coincidence while stalled
    for (int i = 0; i < 200; i++) begin
      ofs_ready = ($urandom % 2) != 0;
      if (i == 77) spread_word = 32'h0002_0009;
      step(1);
    end
    ofs_ready = 1'b1;

    // R3, R7: fractional mode drops mid-period and returns
    cur_req = "R7";
    wait_phase(3);
    frac_en = 1'b0;
    step(4);
    check_val("R3", "frac off sample", longint'(ofs_data), 0);
    frac_en = 1'b1;
    step(1);
    check_val("R7", "restart at phase 0", longint'(ofs_data), 0);

    // R4: depth zero gives zero samples while running
    cur_req = "R4";
    ctrl_word = 32'h0000_0000; spread_word = 32'h0002_0000;
    step(40);
    check_val("R4", "zero depth sample", longint'(ofs_data), 0);
    step(20);
    summary();
  end
endmodule